// File: doc/BRIEF.md
# Operand Specifier Address Generator

This block turns one operand specifier into something an operand-fetch stage can use directly. Each specifier is a mode byte, optionally followed by a 1, 2 or 4 byte offset. The generator classifies the operand as a memory address, a general register, a short literal, an immediate that still sits in the byte stream, or the stack top. For memory operands it computes the effective address. That can take pointer-updating arithmetic on a general register, an offset taken from the byte stream, and, for the indirect forms, one 32-bit pointer read from memory.

The sequencer pulses `start` with the mode byte, the operand size in bytes (1, 2, 4 or 8), the program counter and stack pointer captured at the start of the instruction, and a flag that marks a destination specifier. Offset bytes then arrive on a valid/ready byte stream, least significant byte first. General registers are read through two combinational ports: Rn, and the next register R(n+1), which wraps from R15 to R0. A pointer update is written back through a single write port. Because of this, the source specifier's register side effects are already in the register file before the destination specifier starts. When the result is ready, a one-cycle `done` pulse presents the kind, the address or value, and the two error flags.

Top module: `opspec_agen`

## Requirements
- R1: A mode byte whose two top bits are 00 is a literal. The result is its low six bits sign-extended to 32 bits (range -32..+31), and the kind is 2.
- R2: Mode C (high nibble C) is register direct. The kind is 1, and the result is the register number taken from the low nibble.
- R3: Mode 4 gives address Rn. Mode 6 gives address Rn and then writes Rn+size. Mode D writes Rn-size and gives that new value as the address. The size is the operand size in bytes. All of these have kind 0.
- R4: Mode 7 reads a 32-bit pointer at address Rn and gives the returned word as the address. It also writes Rn+4. The memory request stays asserted with a stable address until the response is valid.
- R5: Mode 5 gives address Rn and writes Rn plus R(n+1). For n=15 the second register is R0.
- R6: Modes 8, 9 and A add a sign-extended byte, halfword or word offset to Rn. Mode B adds a word offset to Rn and reads the pointer stored at that sum.
- R7: Specifiers F0/F1/F2 add a sign-extended byte/halfword/word offset to the instruction-start PC, and F3 is the word-offset pointer form. F4 to F7 do the same relative to the instruction-start SP.
- R8: F8/F9/FA use the following byte/halfword/word, zero-extended, as the address. FB reads the pointer stored at the address given by the following word.
- R9: FC gives kind 4 with the instruction-start SP as the result, and FD gives kind 3. The following raise the operand error with a zero result: mode E, specifiers FE and FF, and a literal or FD used as a destination.
- R10: The address error is raised when the final address of a memory operand exceeds 2^17-1. It is also raised, without issuing a read, when the pointer location of an indirect form exceeds that limit.
- R11: The offset byte input is ready only while offset bytes are being collected. The bytes form the offset least significant first, and gaps in valid do not disturb the value. `done` lasts exactly one cycle.
- R12: During and right after reset, `done`, `off_ready`, `mem_req` and `rf_wr_en` are low. A reset in the middle of a specifier abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `spec_byte` (accepted when idle) |
| spec_byte | input | 8 | Mode byte: high nibble mode, low nibble register or sub-mode |
| is_dest | input | 1 | Specifier is the destination operand |
| op_size | input | 4 | Operand length in bytes |
| pc_start | input | ADDR_W | PC at the beginning of the instruction |
| sp_start | input | ADDR_W | SP at the beginning of the instruction |
| off_valid | input | 1 | Offset byte valid |
| off_data | input | 8 | Offset byte |
| off_ready | output | 1 | Offset byte accepted when valid is high |
| rf_rd_idx | output | REG_IDX_W | Register file read index (Rn) |
| rf_rd_data | input | ADDR_W | Contents of Rn |
| rf_rd2_idx | output | REG_IDX_W | Second read index (R(n+1), wrapping) |
| rf_rd2_data | input | ADDR_W | Contents of R(n+1) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | REG_IDX_W | Register write index |
| rf_wr_data | output | ADDR_W | Register write value |
| mem_req | output | 1 | Pointer read request, held until response |
| mem_addr | output | ADDR_W | Pointer read address |
| mem_rvalid | input | 1 | Pointer read response valid |
| mem_rdata | input | ADDR_W | Pointer read data |
| done | output | 1 | One-cycle result strobe |
| kind | output | 3 | 0 memory, 1 register, 2 literal, 3 immediate, 4 stack |
| result | output | ADDR_W | Address, register number, literal value or SP |
| err_operand | output | 1 | Operand error with this result |
| err_address | output | 1 | Address error with this result |

## Verification
The checker watches handshake and range properties on every cycle. These are: `done` lasts one cycle, a held pointer request keeps its address, no pointer read is issued beyond the address limit, at most one register write happens per specifier, and the offset stream is never open while memory is busy. It also checks that a clean memory result lies within the limit. Whether each mode computes the right address, applies the right sign or zero extension, writes the right register value and wraps autoskip from R15 to R0 can only be shown by the bench's vectors. The same holds for honouring offset gaps and abandoning work on reset. The bench compares each case against hand-derived values from a reference register file.

// File: rtl/opspec_pkg.sv
`timescale 1ns/1ps
package opspec_pkg;

   typedef enum logic [2:0] {
      KIND_MEM = 3'd0,
      KIND_REG = 3'd1,
      KIND_LIT = 3'd2,
      KIND_IMM = 3'd3,
      KIND_STK = 3'd4
   } opnd_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_OFF,
      ST_CALC,
      ST_MEM
   } agen_state_e;

   // Number of offset bytes that follow a mode byte.
   function automatic logic [2:0] offset_len(input logic [7:0] spec);
      logic [2:0] n;
      n = 3'd0;
      case (spec[7:4])
         4'h8:       n = 3'd1;
         4'h9:       n = 3'd2;
         4'hA, 4'hB: n = 3'd4;
         4'hF: begin
            case (spec[3:0])
               4'h0, 4'h4, 4'h8:                      n = 3'd1;
               4'h1, 4'h5, 4'h9:                      n = 3'd2;
               4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB:    n = 3'd4;
               default:                               n = 3'd0;
            endcase
         end
         default:    n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/opspec_offset_rx.sv
`timescale 1ns/1ps
module opspec_offset_rx #(
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   collecting,
   input  logic [$clog2(LANES+1)-1:0] need,
   input  logic                   off_valid,
   input  logic [7:0]             off_data,
   output logic                   off_ready,
   output logic                   last_take,
   output logic [LANES*8-1:0]     word
);
   localparam int CW = $clog2(LANES + 1);

   logic [CW-1:0] cnt_q;
   logic          take;

   assign off_ready = collecting;
   assign take      = collecting & off_valid;
   assign last_take = take && ((cnt_q + 1'b1) == need);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (take)   cnt_q <= cnt_q + 1'b1;
   end

   // One byte lane per offset byte, filled in arrival order (LSB first).
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            lane_q <= '0;
         else if (clear)                        lane_q <= '0;
         else if (take && cnt_q == CW'(g))      lane_q <= off_data;
      end
      assign word[g*8 +: 8] = lane_q;
   end

endmodule

// File: rtl/opspec_ea_calc.sv
`timescale 1ns/1ps
module opspec_ea_calc
   import opspec_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [7:0]    spec,
   input  logic          is_dest,
   input  logic [3:0]    op_size,
   input  logic [AW-1:0] pc_base,
   input  logic [AW-1:0] sp_base,
   input  logic [AW-1:0] rn,
   input  logic [AW-1:0] rn_next,
   input  logic [AW-1:0] off_word,
   output opnd_kind_e    kind,
   output logic [AW-1:0] value,
   output logic          indirect,
   output logic          wr_en,
   output logic [AW-1:0] wr_data,
   output logic          bad_spec
);
   logic [3:0]    mode, sub;
   logic [AW-1:0] sz, soff, zoff;

   assign mode = spec[7:4];
   assign sub  = spec[3:0];
   assign sz   = AW'(op_size);

   always_comb begin
      case (offset_len(spec))
         3'd1: begin
            soff = {{(AW-8){off_word[7]}}, off_word[7:0]};
            zoff = {{(AW-8){1'b0}}, off_word[7:0]};
         end
         3'd2: begin
            soff = {{(AW-16){off_word[15]}}, off_word[15:0]};
            zoff = {{(AW-16){1'b0}}, off_word[15:0]};
         end
         default: begin
            soff = off_word;
            zoff = off_word;
         end
      endcase
   end

   always_comb begin
      kind     = KIND_MEM;
      value    = '0;
      indirect = 1'b0;
      wr_en    = 1'b0;
      wr_data  = rn;
      bad_spec = 1'b0;
      if (spec[7:6] == 2'b00) begin
         kind     = KIND_LIT;
         value    = {{(AW-6){spec[5]}}, spec[5:0]};
         bad_spec = is_dest;
      end else begin
         case (mode)
            4'h4: value = rn;
            4'h5: begin value = rn; wr_en = 1'b1; wr_data = rn + rn_next; end
            4'h6: begin value = rn; wr_en = 1'b1; wr_data = rn + sz; end
            4'h7: begin value = rn; indirect = 1'b1; wr_en = 1'b1; wr_data = rn + AW'(4); end
            4'h8, 4'h9, 4'hA: value = rn + soff;
            4'hB: begin value = rn + soff; indirect = 1'b1; end
            4'hC: begin kind = KIND_REG; value = AW'(sub); end
            4'hD: begin value = rn - sz; wr_en = 1'b1; wr_data = rn - sz; end
            4'hF: begin
               case (sub)
                  4'h0, 4'h1, 4'h2: value = pc_base + soff;
                  4'h3: begin value = pc_base + soff; indirect = 1'b1; end
                  4'h4, 4'h5, 4'h6: value = sp_base + soff;
                  4'h7: begin value = sp_base + soff; indirect = 1'b1; end
                  4'h8, 4'h9, 4'hA: value = zoff;
                  4'hB: begin value = zoff; indirect = 1'b1; end
                  4'hC: begin kind = KIND_STK; value = sp_base; end
                  4'hD: begin kind = KIND_IMM; bad_spec = is_dest; end
                  default: bad_spec = 1'b1;
               endcase
            end
            default: bad_spec = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/opspec_agen.sv
`timescale 1ns/1ps
module opspec_agen
   import opspec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIMIT_BITS = 17,
   parameter int REG_IDX_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [7:0]           spec_byte,
   input  logic                 is_dest,
   input  logic [3:0]           op_size,
   input  logic [ADDR_W-1:0]    pc_start,
   input  logic [ADDR_W-1:0]    sp_start,
   input  logic                 off_valid,
   input  logic [7:0]           off_data,
   output logic                 off_ready,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [ADDR_W-1:0]    rf_rd_data,
   output logic [REG_IDX_W-1:0] rf_rd2_idx,
   input  logic [ADDR_W-1:0]    rf_rd2_data,
   output logic                 rf_wr_en,
   output logic [REG_IDX_W-1:0] rf_wr_idx,
   output logic [ADDR_W-1:0]    rf_wr_data,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [ADDR_W-1:0]    mem_rdata,
   output logic                 done,
   output logic [2:0]           kind,
   output logic [ADDR_W-1:0]    result,
   output logic                 err_operand,
   output logic                 err_address
);
   localparam int LANES = ADDR_W / 8;
   localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'((64'd1 << LIMIT_BITS) - 64'd1);

   if (ADDR_W != 32) begin : g_bad_width
      $error("opspec_agen: ADDR_W must be 32");
   end
   if (LIMIT_BITS < 1 || LIMIT_BITS >= ADDR_W) begin : g_bad_limit
      $error("opspec_agen: LIMIT_BITS out of range");
   end
   if (REG_IDX_W != 4) begin : g_bad_idx
      $error("opspec_agen: register field is four bits");
   end

   agen_state_e         state_q;
   logic [7:0]          spec_q;
   logic                dest_q;
   logic [3:0]          size_q;
   logic [ADDR_W-1:0]   pc_q, sp_q, mem_addr_q, result_q;
   logic [2:0]          need_q;
   logic                done_q, eop_q, eaddr_q;
   opnd_kind_e          kind_q;

   logic                last_take;
   logic [ADDR_W-1:0]   off_word;
   opnd_kind_e          c_kind;
   logic [ADDR_W-1:0]   c_value, c_wr_data;
   logic                c_ind, c_wr_en, c_bad;

   opspec_offset_rx #(.LANES(LANES)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state_q == ST_IDLE && start),
      .collecting (state_q == ST_OFF),
      .need       (need_q),
      .off_valid  (off_valid),
      .off_data   (off_data),
      .off_ready  (off_ready),
      .last_take  (last_take),
      .word       (off_word)
   );

   opspec_ea_calc #(.AW(ADDR_W)) calc_i (
      .spec     (spec_q),
      .is_dest  (dest_q),
      .op_size  (size_q),
      .pc_base  (pc_q),
      .sp_base  (sp_q),
      .rn       (rf_rd_data),
      .rn_next  (rf_rd2_data),
      .off_word (off_word),
      .kind     (c_kind),
      .value    (c_value),
      .indirect (c_ind),
      .wr_en    (c_wr_en),
      .wr_data  (c_wr_data),
      .bad_spec (c_bad)
   );

   assign rf_rd_idx   = spec_q[3:0];
   assign rf_rd2_idx  = spec_q[3:0] + 1'b1;
   assign rf_wr_en    = (state_q == ST_CALC) && c_wr_en;
   assign rf_wr_idx   = spec_q[3:0];
   assign rf_wr_data  = c_wr_data;
   assign mem_req     = (state_q == ST_MEM);
   assign mem_addr    = mem_addr_q;
   assign done        = done_q;
   assign kind        = kind_q;
   assign result      = result_q;
   assign err_operand = eop_q;
   assign err_address = eaddr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         spec_q     <= '0;
         dest_q     <= 1'b0;
         size_q     <= '0;
         pc_q       <= '0;
         sp_q       <= '0;
         need_q     <= '0;
         mem_addr_q <= '0;
         done_q     <= 1'b0;
         kind_q     <= KIND_MEM;
         result_q   <= '0;
         eop_q      <= 1'b0;
         eaddr_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               spec_q  <= spec_byte;
               dest_q  <= is_dest;
               size_q  <= op_size;
               pc_q    <= pc_start;
               sp_q    <= sp_start;
               need_q  <= offset_len(spec_byte);
               state_q <= (offset_len(spec_byte) != 3'd0) ? ST_OFF : ST_CALC;
            end
            ST_OFF: if (last_take) state_q <= ST_CALC;
            ST_CALC: begin
               if (c_bad) begin
                  done_q <= 1'b1; kind_q <= c_kind; result_q <= '0;
                  eop_q  <= 1'b1; eaddr_q <= 1'b0; state_q <= ST_IDLE;
               end else if (c_ind && c_value > ADDR_MAX) begin
                  done_q <= 1'b1; kind_q <= KIND_MEM; result_q <= c_value;
                  eop_q  <= 1'b0; eaddr_q <= 1'b1; state_q <= ST_IDLE;
               end else if (c_ind) begin
                  mem_addr_q <= c_value;
                  state_q    <= ST_MEM;
               end else begin
                  done_q <= 1'b1; kind_q <= c_kind; result_q <= c_value;
                  eop_q  <= 1'b0;
                  eaddr_q <= (c_kind == KIND_MEM) && (c_value > ADDR_MAX);
                  state_q <= ST_IDLE;
               end
            end
            ST_MEM: if (mem_rvalid) begin
               done_q <= 1'b1; kind_q <= KIND_MEM; result_q <= mem_rdata;
               eop_q  <= 1'b0; eaddr_q <= (mem_rdata > ADDR_MAX);
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/opspec_agen_chk.sv
`timescale 1ns/1ps
module opspec_agen_chk #(
   parameter int ADDR_W     = 32,
   parameter int LIMIT_BITS = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              off_ready,
   input logic              rf_wr_en,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              done,
   input logic [2:0]        kind,
   input logic [ADDR_W-1:0] result,
   input logic              err_operand,
   input logic              err_address
);
   localparam logic [ADDR_W-1:0] LIM = ADDR_W'((64'd1 << LIMIT_BITS) - 64'd1);

   a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_stream_vs_mem: assert property (@(posedge clk) disable iff (!rst_n)
      !(off_ready && mem_req));

   a_r11_done_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!off_ready && !mem_req && !rf_wr_en));

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr <= LIM));

   a_r10_clean_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind == 3'd0 && !err_operand && !err_address) |-> (result <= LIM));

   a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |=> !rf_wr_en);

   a_r9_one_error: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(err_operand && err_address));

endmodule

bind opspec_agen opspec_agen_chk #(.ADDR_W(ADDR_W), .LIMIT_BITS(LIMIT_BITS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .off_ready   (off_ready),
   .rf_wr_en    (rf_wr_en),
   .mem_req     (mem_req),
   .mem_addr    (mem_addr),
   .mem_rvalid  (mem_rvalid),
   .done        (done),
   .kind        (kind),
   .result      (result),
   .err_operand (err_operand),
   .err_address (err_address)
);

// File: tb/opspec_agen_tb_top.sv
`timescale 1ns/1ps
module opspec_agen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  spec_byte = '0;
   logic        is_dest = 1'b0;
   logic [3:0]  op_size = 4'd4;
   logic [31:0] pc_start = 32'h0000_4000;
   logic [31:0] sp_start = 32'h0000_8000;
   logic        off_valid = 1'b0;
   logic [7:0]  off_data = '0;
   logic        off_ready;
   logic [3:0]  rf_rd_idx, rf_rd2_idx, rf_wr_idx;
   logic [31:0] rf_rd_data, rf_rd2_data, rf_wr_data;
   logic        rf_wr_en;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic [2:0]  kind;
   logic [31:0] result;
   logic        err_operand, err_address;

   always #10 clk = ~clk;   // 50 MHz

   opspec_agen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .spec_byte(spec_byte),
      .is_dest(is_dest), .op_size(op_size), .pc_start(pc_start), .sp_start(sp_start),
      .off_valid(off_valid), .off_data(off_data), .off_ready(off_ready),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_rd2_idx(rf_rd2_idx), .rf_rd2_data(rf_rd2_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .done(done), .kind(kind), .result(result),
      .err_operand(err_operand), .err_address(err_address)
   );

   // Reference register file: Ri starts at 0x1000 + i*0x100.
   logic [31:0] regs [16];
   logic        init_regs = 1'b0;
   always @(posedge clk) begin
      if (init_regs) begin
         for (int i = 0; i < 16; i++) regs[i] <= 32'h1000 + 32'(i) * 32'h100;
      end else if (rf_wr_en) begin
         regs[rf_wr_idx] <= rf_wr_data;
      end
   end
   assign rf_rd_data  = regs[rf_rd_idx];
   assign rf_rd2_data = regs[rf_rd2_idx];

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0]  spec;
      logic        dest;
      logic [3:0]  size;
      logic [2:0]  nb;
      logic [31:0] off;
      logic [31:0] paddr;
      logic [31:0] ptr;
      logic [2:0]  kind;
      logic [31:0] res;
      logic        eop;
      logic        eadr;
      logic [3:0]  creg;
      logic [31:0] cval;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{8'h05,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd2,32'h5,1'b0,1'b0,4'd1,32'h1100,4'd1},        // R1
      '{8'h20,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd2,32'hFFFFFFE0,1'b0,1'b0,4'd1,32'h1100,4'd1}, // R1
      '{8'h2A,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd2,32'hFFFFFFEA,1'b0,1'b0,4'd1,32'h1100,4'd1}, // R1
      '{8'h1F,1'b1,4'd4,3'd0,32'h0,32'h0,32'h0,3'd2,32'h0,1'b1,1'b0,4'd1,32'h1100,4'd9},        // R9
      '{8'hC3,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd1,32'h3,1'b0,1'b0,4'd3,32'h1300,4'd2},        // R2
      '{8'hC0,1'b1,4'd4,3'd0,32'h0,32'h0,32'h0,3'd1,32'h0,1'b0,1'b0,4'd0,32'h1000,4'd2},        // R2
      '{8'h42,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h1200,1'b0,1'b0,4'd2,32'h1200,4'd3},     // R3
      '{8'hD5,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h14FC,1'b0,1'b0,4'd5,32'h14FC,4'd3},     // R3
      '{8'hD5,1'b0,4'd8,3'd0,32'h0,32'h0,32'h0,3'd0,32'h14F8,1'b0,1'b0,4'd5,32'h14F8,4'd3},     // R3
      '{8'h66,1'b0,4'd2,3'd0,32'h0,32'h0,32'h0,3'd0,32'h1600,1'b0,1'b0,4'd6,32'h1602,4'd3},     // R3
      '{8'h6A,1'b0,4'd1,3'd0,32'h0,32'h0,32'h0,3'd0,32'h1A00,1'b0,1'b0,4'd10,32'h1A01,4'd3},    // R3
      '{8'h77,1'b0,4'd4,3'd0,32'h0,32'h1700,32'h12345,3'd0,32'h12345,1'b0,1'b0,4'd7,32'h1704,4'd4}, // R4
      '{8'h5F,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h1F00,1'b0,1'b0,4'd15,32'h2F00,4'd5},    // R5
      '{8'h53,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h1300,1'b0,1'b0,4'd3,32'h2700,4'd5},     // R5
      '{8'h84,1'b0,4'd4,3'd1,32'hF0,32'h0,32'h0,3'd0,32'h13F0,1'b0,1'b0,4'd4,32'h1400,4'd6},    // R6
      '{8'h98,1'b0,4'd4,3'd2,32'h100,32'h0,32'h0,3'd0,32'h1900,1'b0,1'b0,4'd8,32'h1800,4'd6},   // R6
      '{8'h9B,1'b0,4'd4,3'd2,32'h8000,32'h0,32'h0,3'd0,32'hFFFF9B00,1'b0,1'b1,4'd11,32'h1B00,4'd10}, // R10
      '{8'hA1,1'b0,4'd4,3'd4,32'h20,32'h0,32'h0,3'd0,32'h1120,1'b0,1'b0,4'd1,32'h1100,4'd6},    // R6
      '{8'hB2,1'b0,4'd4,3'd4,32'h10,32'h1210,32'h800,3'd0,32'h800,1'b0,1'b0,4'd2,32'h1200,4'd6}, // R6
      '{8'hF0,1'b0,4'd4,3'd1,32'hFE,32'h0,32'h0,3'd0,32'h3FFE,1'b0,1'b0,4'd0,32'h1000,4'd7},    // R7
      '{8'hF5,1'b0,4'd4,3'd2,32'hFFF0,32'h0,32'h0,3'd0,32'h7FF0,1'b0,1'b0,4'd0,32'h1000,4'd7},  // R7
      '{8'hF3,1'b0,4'd4,3'd4,32'h100,32'h4100,32'h9999,3'd0,32'h9999,1'b0,1'b0,4'd0,32'h1000,4'd7}, // R7
      '{8'hF6,1'b0,4'd4,3'd4,32'hFFFFFF00,32'h0,32'h0,3'd0,32'h7F00,1'b0,1'b0,4'd0,32'h1000,4'd7}, // R7
      '{8'hF8,1'b0,4'd4,3'd1,32'h80,32'h0,32'h0,3'd0,32'h80,1'b0,1'b0,4'd0,32'h1000,4'd8},      // R8
      '{8'hF9,1'b0,4'd4,3'd2,32'hFFF0,32'h0,32'h0,3'd0,32'hFFF0,1'b0,1'b0,4'd0,32'h1000,4'd8},  // R8
      '{8'hFB,1'b0,4'd4,3'd4,32'h300,32'h300,32'h1ABCD,3'd0,32'h1ABCD,1'b0,1'b0,4'd0,32'h1000,4'd8}, // R8
      '{8'hFA,1'b0,4'd4,3'd4,32'h20000,32'h0,32'h0,3'd0,32'h20000,1'b0,1'b1,4'd0,32'h1000,4'd10}, // R10
      '{8'hFB,1'b0,4'd4,3'd4,32'h20000,32'h0,32'h0,3'd0,32'h20000,1'b0,1'b1,4'd0,32'h1000,4'd10}, // R10
      '{8'hFB,1'b0,4'd4,3'd4,32'h300,32'h300,32'h30000,3'd0,32'h30000,1'b0,1'b1,4'd0,32'h1000,4'd10}, // R10
      '{8'hFC,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd4,32'h8000,1'b0,1'b0,4'd0,32'h1000,4'd9},     // R9
      '{8'hFC,1'b1,4'd4,3'd0,32'h0,32'h0,32'h0,3'd4,32'h8000,1'b0,1'b0,4'd0,32'h1000,4'd9},     // R9
      '{8'hFD,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd3,32'h0,1'b0,1'b0,4'd0,32'h1000,4'd9},        // R9
      '{8'hFD,1'b1,4'd4,3'd0,32'h0,32'h0,32'h0,3'd3,32'h0,1'b1,1'b0,4'd0,32'h1000,4'd9},        // R9
      '{8'hE0,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h0,1'b1,1'b0,4'd0,32'h1000,4'd9},        // R9
      '{8'hFE,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h0,1'b1,1'b0,4'd0,32'h1000,4'd9},        // R9
      '{8'hFF,1'b0,4'd4,3'd0,32'h0,32'h0,32'h0,3'd0,32'h0,1'b1,1'b0,4'd0,32'h1000,4'd9}         // R9
   };

   logic [2:0]  got_kind;
   logic [31:0] got_res, seen_paddr;
   logic        got_eop, got_eadr, got_done;

   task automatic run_spec(input logic [7:0] sp, input logic d, input logic [3:0] sz,
                           input logic [2:0] nb, input logic [31:0] off, input logic [31:0] ptr,
                           input bit gap);
      int  idx;
      logic rdy;
      @(negedge clk); init_regs = 1'b1;
      @(negedge clk); init_regs = 1'b0;
      spec_byte = sp; is_dest = d; op_size = sz; start = 1'b1;
      @(negedge clk); start = 1'b0;
      idx = 0; got_done = 1'b0; seen_paddr = '0;
      for (int cyc = 0; cyc < 60 && !got_done; cyc++) begin
         if (done) begin
            got_done = 1'b1;
            got_kind = kind; got_res = result; got_eop = err_operand; got_eadr = err_address;
         end else begin
            off_valid  = (idx < int'(nb)) && !(gap && (cyc % 2 == 1));
            off_data   = 8'(off >> (idx * 8));
            mem_rvalid = mem_req;
            mem_rdata  = ptr;
            if (mem_req) seen_paddr = mem_addr;
            rdy = off_ready;
            @(posedge clk);
            if (off_valid && rdy) idx++;
            @(negedge clk);
            off_valid = 1'b0; mem_rvalid = 1'b0;
         end
      end
      check("R11", "done seen", {31'd0, got_done}, 32'd1);
   endtask

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12", "done in reset", {31'd0, done}, 32'd0);
      check("R12", "off_ready in reset", {31'd0, off_ready}, 32'd0);
      check("R12", "mem_req in reset", {31'd0, mem_req}, 32'd0);
      check("R12", "rf_wr_en in reset", {31'd0, rf_wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", "idle after reset", {30'd0, off_ready, done}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
         run_spec(VEC[v].spec, VEC[v].dest, VEC[v].size, VEC[v].nb, VEC[v].off, VEC[v].ptr, 1'b0);
         check(tag, "kind", {29'd0, got_kind}, {29'd0, VEC[v].kind});
         check(tag, "result", got_res, VEC[v].res);
         check(tag, "err_operand", {31'd0, got_eop}, {31'd0, VEC[v].eop});
         check(tag, "err_address", {31'd0, got_eadr}, {31'd0, VEC[v].eadr});
         check(tag, "pointer address", seen_paddr, VEC[v].paddr);
         check(tag, "register after", regs[VEC[v].creg], VEC[v].cval);
      end

      // R11: offset bytes with gaps in valid still form 0x0100
      run_spec(8'h98, 1'b0, 4'd4, 3'd2, 32'h100, 32'h0, 1'b1);
      check("R11", "gapped offset result", got_res, 32'h1900);
      // R11: done lasts one cycle, stream closed afterwards
      @(negedge clk);
      check("R11", "done dropped", {31'd0, done}, 32'd0);
      check("R11", "ready low when idle", {31'd0, off_ready}, 32'd0);

      // R12: reset during offset collection abandons the specifier
      @(negedge clk); spec_byte = 8'hA1; is_dest = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R11", "ready while collecting", {31'd0, off_ready}, 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R12", "ready dropped by reset", {31'd0, off_ready}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R12", "no done after abandon", {30'd0, off_ready, done}, 32'd0);
      run_spec(8'h42, 1'b0, 4'd4, 3'd0, 32'h0, 32'h0, 1'b0);
      check("R12", "works after reset", got_res, 32'h1200);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule